// File: doc/BRIEF.md
# Dual-Channel Indirect Register Front End

This block is the bus-facing register front end of a two-channel serial communications controller. A host reaches each channel through two ports: a control port, reached through a per-channel register pointer, and a direct data port. A control write made while the pointer is zero loads a register number into the pointer. The next control access on that channel reads or writes the selected register, and the pointer then returns to zero. A control read made while the pointer is zero returns the channel's main status byte.

The block holds the per-channel write registers and one master-control register shared by both channels. It peels command fields off two registers and turns them into one-cycle pulses. It muxes status supplied by the serial engines onto the read path. The serial engines, baud generators, clock recovery and FIFOs live outside the block. They supply status through input ports and consume the stored configuration through flat output vectors.

After every access the block raises a busy flag for a fixed recovery window. Any access that arrives inside that window is counted in a saturating violation counter, and it is still carried out.

Top module: `sio_regfront`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every stored register, both pointers, `rd_data`, `acc_err`, `busy`, `viol_cnt` and every pulse output.
- R2: A control write with the pointer at zero and a data value of 0..15 loads the pointer. The next control access on that channel targets the loaded register. After that access the pointer is zero again. Writes to registers 1..6, 10..13 and 15 store all 8 bits, which appear in byte slot n (bits 8n+7:8n) of `cfg_a`/`cfg_b`. Slots 0 and 8 read as zero.
- R3: A control read with the pointer at zero returns that channel's status byte (`stat0_a`/`stat0_b`: bit0 receive character available, bit1 baud counter zero, bit2 transmit buffer empty, bit3 carrier detect, bit4 sync/abort, bit5 clear-to-send, bit6 transmit underrun, bit7 break).
- R4: A write to register 7 goes to the sync register (`cfg` slot 7) when bit 0 of that channel's register 15 is 0. It goes to the alternate option register (`alt7_a`/`alt7_b`) when that bit is 1. The other register of the pair is left unchanged.
- R5: Register 9 is a single register shared by both channels and appears in slot 9 of both `cfg` vectors. Only data bits 5:0 are stored. Bits 7:6 appear on `mic_cmd` for exactly the one cycle after the write.
- R6: A write to register 14 stores only data bits 4:0. A non-zero command code c in data bits 7:5 (1..7) raises bit c-1 of that channel's `dpll_cmd` for exactly one cycle after the write. Code 0 raises nothing.
- R7: Reading register 3 through channel A returns `{2'b00, irq_pend}` (bit0 B ext/status, bit1 B transmit, bit2 B receive, bit3 A ext/status, bit4 A transmit, bit5 A receive). The same read through channel B returns 0x00 without an error.
- R8: Reading register 1 returns that channel's special-condition byte (`spc_a`/`spc_b`: bit0 all sent, bits 3:1 residue code, bit4 parity error, bit5 receive overrun, bit6 CRC/framing error, bit7 end of frame). Reading register 10 returns that channel's `dpll_st` byte.
- R9: Register 8 can be reached through the pointer or through the data port (`acc_dport`=1). A write sets `txd_a`/`txd_b`, and the matching `tx_load` is high for the one cycle after the write. A read returns `rxd_a`/`rxd_b`. Data-port accesses leave the pointer unchanged.
- R10: `busy` is high for exactly the 4 cycles following any access. An access made while `busy` is high increments `viol_cnt`, which saturates at its maximum, and the access still takes effect.
- R11: A pointer-load value above 15 leaves the pointer at zero. A read of register 2, 4..7, 9 or 11..15 returns 0x00 and clears the pointer. Both cases raise `acc_err` for exactly one cycle.
- R12: `rd_data` is updated on the clock edge of every read access and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle high |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_chan | input | 1 | 0 channel A, 1 channel B |
| acc_dport | input | 1 | 1 data port, 0 control port |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| acc_err | output | 1 | One-cycle error pulse |
| busy | output | 1 | Recovery window active |
| viol_cnt | output | 8 | Saturating recovery-violation count |
| stat0_a | input | 8 | Channel A main status |
| stat0_b | input | 8 | Channel B main status |
| spc_a | input | 8 | Channel A special-condition status |
| spc_b | input | 8 | Channel B special-condition status |
| dpll_st_a | input | 8 | Channel A clock-recovery status |
| dpll_st_b | input | 8 | Channel B clock-recovery status |
| irq_pend | input | 6 | Interrupt pending bits of both channels |
| rxd_a | input | 8 | Channel A received byte |
| rxd_b | input | 8 | Channel B received byte |
| txd_a | output | 8 | Channel A transmit byte |
| txd_b | output | 8 | Channel B transmit byte |
| tx_load_a | output | 1 | Channel A transmit byte written |
| tx_load_b | output | 1 | Channel B transmit byte written |
| cfg_a | output | 128 | Channel A write registers, byte slot per number |
| cfg_b | output | 128 | Channel B write registers, byte slot per number |
| alt7_a | output | 8 | Channel A alternate option register |
| alt7_b | output | 8 | Channel B alternate option register |
| dpll_cmd_a | output | 7 | Channel A clock-recovery command pulses |
| dpll_cmd_b | output | 7 | Channel B clock-recovery command pulses |
| mic_cmd | output | 2 | Shared reset command pulse |

## Verification
The assertions assume that the host drives `acc_en` low throughout reset and that the access inputs are stable around each rising edge. They also assume that at most one access is presented per cycle, so the two channels never update the shared register in the same cycle. The stimulus drives every input on the falling edge and holds `acc_en` low while reset is applied. It spaces ordinary accesses by more than the recovery window. Accesses are run back to back only in the bursts meant to exercise the violation counter and its saturation.

// File: rtl/sio_pkg.sv
// Package: shared sizes and register numbers of the dual-channel register
// front end. Assumes 8-bit registers and sixteen register numbers per channel.
package sio_pkg;
    localparam int DW         = 8;
    localparam int NREG       = 16;
    localparam int PTR_W      = $clog2(NREG);
    localparam int CFG_W      = NREG * DW;
    localparam int IPEND_W    = 6;
    localparam int DCMD_W     = 7;
    localparam int CODE_W     = $clog2(DCMD_W + 1);

    // Register numbers whose behaviour differs from a plain byte store
    localparam logic [PTR_W-1:0] RN_PTR   = 4'd0;
    localparam logic [PTR_W-1:0] RN_SPC   = 4'd1;
    localparam logic [PTR_W-1:0] RN_IPEND = 4'd3;
    localparam logic [PTR_W-1:0] RN_SYNC  = 4'd7;
    localparam logic [PTR_W-1:0] RN_DATA  = 4'd8;
    localparam logic [PTR_W-1:0] RN_MIC   = 4'd9;
    localparam logic [PTR_W-1:0] RN_DPST  = 4'd10;
    localparam logic [PTR_W-1:0] RN_DPLL  = 4'd14;
    localparam logic [PTR_W-1:0] RN_ICTL  = 4'd15;

    localparam logic [DW-1:0] MIC_KEEP  = 8'h3F;
    localparam logic [DW-1:0] DPLL_KEEP = 8'h1F;
endpackage

// File: rtl/sio_chan_regs.sv
// Module: one channel's pointer, write-register storage, command decode and
// read mux. Assumes at most one of ctl_acc / dat_acc is high per cycle.
// The shared master-control register lives in the top; this module only
// raises a write request for it and shows its value in slot 9.
module sio_chan_regs
    import sio_pkg::*;
#(
    parameter bit HAS_IPEND = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_acc,
    input  logic               dat_acc,
    input  logic               wr,
    input  logic [DW-1:0]      wdata,
    input  logic [DW-1:0]      st_main,
    input  logic [DW-1:0]      st_spc,
    input  logic [DW-1:0]      st_dpll,
    input  logic [IPEND_W-1:0] ipend,
    input  logic [DW-1:0]      rxd,
    input  logic [DW-1:0]      mic_val,
    output logic [CFG_W-1:0]   cfg,
    output logic [DW-1:0]      alt7,
    output logic [DW-1:0]      txd,
    output logic               tx_load,
    output logic [DCMD_W-1:0]  dpll_cmd,
    output logic [DW-1:0]      rd_val,
    output logic               err,
    output logic               mic_we
);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_d;
    logic [NREG-1:0]   slot_we;
    logic              alt_we;
    logic              tx_we;
    logic [DCMD_W-1:0] dcmd_d;
    logic              alt_sel;

    // Option-select bit taken from this channel's register 15
    assign alt_sel = cfg[RN_ICTL*DW];

    // Decode one access into pointer update, write enables and read value
    always_comb begin
        ptr_d   = ptr_q;
        slot_we = '0;
        alt_we  = 1'b0;
        tx_we   = 1'b0;
        mic_we  = 1'b0;
        rd_val  = '0;
        err     = 1'b0;
        if (dat_acc) begin
            if (wr) tx_we  = 1'b1;
            else    rd_val = rxd;
        end else if (ctl_acc) begin
            if (ptr_q == RN_PTR) begin
                if (wr) begin
                    if (wdata[DW-1:PTR_W] != '0) err = 1'b1;
                    else                         ptr_d = wdata[PTR_W-1:0];
                end else begin
                    rd_val = st_main;
                end
            end else begin
                ptr_d = RN_PTR;
                if (wr) begin
                    if (ptr_q == RN_DATA)      tx_we  = 1'b1;
                    else if (ptr_q == RN_MIC)  mic_we = 1'b1;
                    else if (ptr_q == RN_SYNC && alt_sel) alt_we = 1'b1;
                    else                       slot_we[ptr_q] = 1'b1;
                end else begin
                    case (ptr_q)
                        RN_SPC:   rd_val = st_spc;
                        RN_IPEND: rd_val = HAS_IPEND ? {{(DW-IPEND_W){1'b0}}, ipend} : '0;
                        RN_DATA:  rd_val = rxd;
                        RN_DPST:  rd_val = st_dpll;
                        default:  err = 1'b1;
                    endcase
                end
            end
        end
    end

    // Turn the command field of register 14 into a one-hot pulse vector
    always_comb begin
        dcmd_d = '0;
        if (slot_we[RN_DPLL] && wdata[DW-1:DW-3] != '0)
            dcmd_d[wdata[DW-1:DW-3] - 3'd1] = 1'b1;
    end

    // Register pointer
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= RN_PTR;
        else        ptr_q <= ptr_d;
    end

    // Alternate option register, transmit byte and pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt7     <= '0;
            txd      <= '0;
            tx_load  <= 1'b0;
            dpll_cmd <= '0;
        end else begin
            if (alt_we) alt7 <= wdata;
            if (tx_we)  txd  <= wdata;
            tx_load  <= tx_we;
            dpll_cmd <= dcmd_d;
        end
    end

    // One storage byte per register number; some slots hold no storage
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == RN_PTR || g == RN_DATA) begin : g_none
            assign cfg[g*DW +: DW] = '0;
        end else if (g == RN_MIC) begin : g_shared
            assign cfg[g*DW +: DW] = mic_val;
        end else begin : g_store
            localparam logic [DW-1:0] KEEP = (g == RN_DPLL) ? DPLL_KEEP : {DW{1'b1}};
            logic [DW-1:0] q;
            // Store the kept bits of a write aimed at this slot
            always_ff @(posedge clk) begin
                if (!rst_n)          q <= '0;
                else if (slot_we[g]) q <= wdata & KEEP;
            end
            assign cfg[g*DW +: DW] = q;
        end
    end

endmodule

// File: rtl/sio_recovery.sv
// Module: recovery-window tracker. After each access, busy is held high for
// BUSY_CYC cycles. An access that arrives while busy is high increments a
// saturating violation counter. Assumes acc is a one-cycle-per-access strobe.
module sio_recovery #(
    parameter int BUSY_CYC = 4,
    parameter int VCNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    output logic              busy,
    output logic [VCNT_W-1:0] viol_cnt
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(BUSY_CYC);
    localparam logic [VCNT_W-1:0] VMAX     = {VCNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Reload the window on access, otherwise count it down
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (acc)  cnt_q <= CNT_LOAD;
        else if (busy) cnt_q <= cnt_q - 1'b1;
    end

    // Count accesses that land inside the window, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                                viol_cnt <= '0;
        else if (acc && busy && viol_cnt != VMAX)  viol_cnt <= viol_cnt + 1'b1;
    end
endmodule

// File: rtl/sio_regfront.sv
// Module: top of the dual-channel indirect register front end. Routes each
// access to one channel, holds the shared master-control register, registers
// read data and the error pulse, and tracks the recovery window.
// Assumes one access per cycle and a synchronous active-low reset.
module sio_regfront
    import sio_pkg::*;
#(
    parameter int BUSY_CYC = 4,
    parameter int VCNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic               acc_chan,
    input  logic               acc_dport,
    input  logic [DW-1:0]      acc_wdata,
    output logic [DW-1:0]      rd_data,
    output logic               acc_err,
    output logic               busy,
    output logic [VCNT_W-1:0]  viol_cnt,
    input  logic [DW-1:0]      stat0_a,
    input  logic [DW-1:0]      stat0_b,
    input  logic [DW-1:0]      spc_a,
    input  logic [DW-1:0]      spc_b,
    input  logic [DW-1:0]      dpll_st_a,
    input  logic [DW-1:0]      dpll_st_b,
    input  logic [IPEND_W-1:0] irq_pend,
    input  logic [DW-1:0]      rxd_a,
    input  logic [DW-1:0]      rxd_b,
    output logic [DW-1:0]      txd_a,
    output logic [DW-1:0]      txd_b,
    output logic               tx_load_a,
    output logic               tx_load_b,
    output logic [CFG_W-1:0]   cfg_a,
    output logic [CFG_W-1:0]   cfg_b,
    output logic [DW-1:0]      alt7_a,
    output logic [DW-1:0]      alt7_b,
    output logic [DCMD_W-1:0]  dpll_cmd_a,
    output logic [DCMD_W-1:0]  dpll_cmd_b,
    output logic [1:0]         mic_cmd
);
    localparam int NCH = 2;

    logic [DW-1:0]     st_main [NCH];
    logic [DW-1:0]     st_spc  [NCH];
    logic [DW-1:0]     st_dpll [NCH];
    logic [DW-1:0]     rxd     [NCH];
    logic [CFG_W-1:0]  cfg     [NCH];
    logic [DW-1:0]     alt7    [NCH];
    logic [DW-1:0]     txd     [NCH];
    logic              txl     [NCH];
    logic [DCMD_W-1:0] dcmd    [NCH];
    logic [DW-1:0]     rd_val  [NCH];
    logic              err     [NCH];
    logic              mic_we  [NCH];
    logic [DW-1:0]     mic_q;
    logic              sel_mic_we;

    assign st_main = '{stat0_a, stat0_b};
    assign st_spc  = '{spc_a, spc_b};
    assign st_dpll = '{dpll_st_a, dpll_st_b};
    assign rxd     = '{rxd_a, rxd_b};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = acc_en && (acc_chan == c[0]);
        sio_chan_regs #(.HAS_IPEND(c == 0)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_acc  (hit && !acc_dport),
            .dat_acc  (hit && acc_dport),
            .wr       (acc_wr),
            .wdata    (acc_wdata),
            .st_main  (st_main[c]),
            .st_spc   (st_spc[c]),
            .st_dpll  (st_dpll[c]),
            .ipend    (irq_pend),
            .rxd      (rxd[c]),
            .mic_val  (mic_q),
            .cfg      (cfg[c]),
            .alt7     (alt7[c]),
            .txd      (txd[c]),
            .tx_load  (txl[c]),
            .dpll_cmd (dcmd[c]),
            .rd_val   (rd_val[c]),
            .err      (err[c]),
            .mic_we   (mic_we[c])
        );
    end

    assign cfg_a      = cfg[0];
    assign cfg_b      = cfg[1];
    assign alt7_a     = alt7[0];
    assign alt7_b     = alt7[1];
    assign txd_a      = txd[0];
    assign txd_b      = txd[1];
    assign tx_load_a  = txl[0];
    assign tx_load_b  = txl[1];
    assign dpll_cmd_a = dcmd[0];
    assign dpll_cmd_b = dcmd[1];

    assign sel_mic_we = mic_we[0] || mic_we[1];

    // Shared master-control register: keep low bits, pulse the command bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mic_q   <= '0;
            mic_cmd <= '0;
        end else begin
            if (sel_mic_we) mic_q <= acc_wdata & MIC_KEEP;
            mic_cmd <= sel_mic_we ? acc_wdata[DW-1:DW-2] : 2'b00;
        end
    end

    // Capture read data of the addressed channel and its error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            acc_err <= 1'b0;
        end else begin
            if (acc_en && !acc_wr) rd_data <= rd_val[acc_chan];
            acc_err <= acc_en && err[acc_chan];
        end
    end

    sio_recovery #(.BUSY_CYC(BUSY_CYC), .VCNT_W(VCNT_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc_en),
        .busy     (busy),
        .viol_cnt (viol_cnt)
    );

endmodule

// File: rtl/sio_regfront_chk.sv
// Module: port-level checker for sio_regfront, attached with bind.
// Assumes acc_en is low during reset.
module sio_regfront_chk #(
    parameter int VCNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_chan,
    input logic              busy,
    input logic [VCNT_W-1:0] viol_cnt,
    input logic [7:0]        rd_data,
    input logic              acc_err,
    input logic              tx_load_a,
    input logic              tx_load_b,
    input logic [6:0]        dpll_cmd_a,
    input logic [6:0]        dpll_cmd_b,
    input logic [1:0]        mic_cmd
);
    p_busy_follows_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> busy);

    p_viol_only_on_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_en) |-> $stable(viol_cnt));

    p_err_from_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_en));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(acc_en) && !$past(acc_wr)) |-> $stable(rd_data));

    p_txload_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_a |-> ($past(acc_en) && $past(acc_wr) && !$past(acc_chan)));

    p_txload_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_b |-> ($past(acc_en) && $past(acc_wr) && $past(acc_chan)));

    p_dpll_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dpll_cmd_a) && $onehot0(dpll_cmd_b));

    p_dpll_one_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((dpll_cmd_a != 7'd0) && (dpll_cmd_b != 7'd0)));

    p_mic_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mic_cmd != 2'b00) |-> ($past(acc_en) && $past(acc_wr)));
endmodule

bind sio_regfront sio_regfront_chk #(.VCNT_W(VCNT_W)) u_chk (.*);

// File: tb/sio_regfront_bench.sv
// Bench: behavioural reference model updated on each rising edge and compared
// with every output on each falling edge, plus directed checks.
module sio_regfront_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 0, acc_wr = 0, acc_chan = 0, acc_dport = 0;
    logic [7:0] acc_wdata = 0;
    logic [7:0] stat0_a = 0, stat0_b = 0, spc_a = 0, spc_b = 0;
    logic [7:0] dpll_st_a = 0, dpll_st_b = 0, rxd_a = 0, rxd_b = 0;
    logic [5:0] irq_pend = 0;
    logic [7:0] rd_data, viol_cnt, txd_a, txd_b, alt7_a, alt7_b;
    logic acc_err, busy, tx_load_a, tx_load_b;
    logic [127:0] cfg_a, cfg_b;
    logic [6:0] dpll_cmd_a, dpll_cmd_b;
    logic [1:0] mic_cmd;

    always #4 clk = ~clk;

    sio_regfront u_sio_regfront (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit cmp_on = 0;

    // Reference model state
    int         m_ptr [2];
    logic [7:0] m_wr  [2][16];
    logic [7:0] m_alt [2];
    logic [7:0] m_tx  [2];
    logic       m_txl [2];
    logic [6:0] m_dc  [2];
    logic [7:0] m_wr9, m_rd;
    logic [1:0] m_mic;
    logic       m_err;
    int         m_cnt, m_viol;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [127:0] exp_cfg(int c);
        logic [127:0] v = '0;
        for (int i = 0; i < 16; i++)
            v[i*8 +: 8] = (i == 0 || i == 8) ? 8'h00 : (i == 9 ? m_wr9 : m_wr[c][i]);
        return v;
    endfunction

    // Model: one step per rising edge
    always @(posedge clk) begin
        int c, r;
        logic [7:0] v;
        cyc++;
        cmp_on = 1;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_ptr[k] = 0; m_alt[k] = 0; m_tx[k] = 0; m_txl[k] = 0; m_dc[k] = 0;
                for (int j = 0; j < 16; j++) m_wr[k][j] = 0;
            end
            m_wr9 = 0; m_rd = 0; m_mic = 0; m_err = 0; m_cnt = 0; m_viol = 0;
        end else begin
            m_txl[0] = 0; m_txl[1] = 0; m_dc[0] = 0; m_dc[1] = 0; m_mic = 0; m_err = 0;
            if (acc_en) begin
                if (m_cnt > 0 && m_viol < 255) m_viol++;
                m_cnt = 4;
                c = acc_chan;
                v = acc_wdata;
                if (acc_dport) begin
                    if (acc_wr) begin m_tx[c] = v; m_txl[c] = 1; end
                    else m_rd = c ? rxd_b : rxd_a;
                end else if (m_ptr[c] == 0) begin
                    if (acc_wr) begin
                        if (v > 15) m_err = 1; else m_ptr[c] = v;
                    end else m_rd = c ? stat0_b : stat0_a;
                end else begin
                    r = m_ptr[c];
                    m_ptr[c] = 0;
                    if (acc_wr) begin
                        if (r == 8) begin m_tx[c] = v; m_txl[c] = 1; end
                        else if (r == 9) begin m_wr9 = v & 8'h3F; m_mic = v[7:6]; end
                        else if (r == 7 && m_wr[c][15][0]) m_alt[c] = v;
                        else if (r == 14) begin
                            m_wr[c][14] = v & 8'h1F;
                            if (v[7:5] != 0) m_dc[c] = 7'(1 << (v[7:5] - 1));
                        end else m_wr[c][r] = v;
                    end else begin
                        if (r == 1) m_rd = c ? spc_b : spc_a;
                        else if (r == 3) m_rd = c ? 8'h00 : {2'b00, irq_pend};
                        else if (r == 8) m_rd = c ? rxd_b : rxd_a;
                        else if (r == 10) m_rd = c ? dpll_st_b : dpll_st_a;
                        else begin m_rd = 8'h00; m_err = 1; end
                    end
                end
            end else if (m_cnt > 0) m_cnt--;
        end
    end

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R12 rd_data", rd_data, m_rd);
            chk("R11 acc_err", acc_err, m_err);
            chk("R10 busy", busy, m_cnt != 0);
            chk("R10 viol_cnt", viol_cnt, m_viol[7:0]);
            chk("R9 txd_a", txd_a, m_tx[0]);
            chk("R9 txd_b", txd_b, m_tx[1]);
            chk("R9 tx_load_a", tx_load_a, m_txl[0]);
            chk("R9 tx_load_b", tx_load_b, m_txl[1]);
            chk("R2 cfg_a", cfg_a, exp_cfg(0));
            chk("R2 cfg_b", cfg_b, exp_cfg(1));
            chk("R4 alt7_a", alt7_a, m_alt[0]);
            chk("R4 alt7_b", alt7_b, m_alt[1]);
            chk("R6 dpll_cmd_a", dpll_cmd_a, m_dc[0]);
            chk("R6 dpll_cmd_b", dpll_cmd_b, m_dc[1]);
            chk("R5 mic_cmd", mic_cmd, m_mic);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One access, then a gap longer than the recovery window
    task automatic acc(bit ch, bit dport, bit wr, logic [7:0] v, int gap = 5);
        @(negedge clk);
        acc_en = 1; acc_chan = ch; acc_dport = dport; acc_wr = wr; acc_wdata = v;
        @(negedge clk);
        acc_en = 0;
        idle(gap);
    endtask

    task automatic wreg(bit ch, int r, logic [7:0] v);
        acc(ch, 0, 1, 8'(r));
        acc(ch, 0, 1, v);
    endtask

    task automatic rreg(bit ch, int r);
        acc(ch, 0, 1, 8'(r));
        acc(ch, 0, 0, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        chk("R1 rd_data reset", rd_data, 8'h00);
        chk("R1 busy reset", busy, 1'b0);
        chk("R1 cfg_a reset", cfg_a, 128'h0);
        chk("R1 viol reset", viol_cnt, 8'h00);
        rst_n = 1;
        idle(2);

        // R3: status read with pointer at zero
        stat0_a = 8'hA5; stat0_b = 8'h3C;
        acc(0, 0, 0, 8'h00);
        chk("R3 status A", rd_data, 8'hA5);
        acc(1, 0, 0, 8'h00);
        chk("R3 status B", rd_data, 8'h3C);

        // R2: plain registers on both channels
        for (int r = 1; r < 16; r++)
            if (r != 7 && r != 8 && r != 9 && r != 14 && r != 15) begin
                wreg(0, r, 8'(8'h10 + r));
                wreg(1, r, 8'(8'hE0 + r));
            end
        chk("R2 slot 5 A", cfg_a[5*8 +: 8], 8'h15);
        chk("R2 slot 12 B", cfg_b[12*8 +: 8], 8'hEC);
        // Pointer returned to zero: a control read now yields status
        acc(0, 0, 0, 8'h00);
        chk("R2 pointer cleared", rd_data, 8'hA5);

        // R4: register 7 aliasing by register 15 bit 0
        wreg(0, 7, 8'h7E);
        wreg(0, 15, 8'h01);
        wreg(0, 7, 8'h3C);
        chk("R4 sync kept", cfg_a[7*8 +: 8], 8'h7E);
        chk("R4 alternate written", alt7_a, 8'h3C);
        wreg(0, 15, 8'h00);
        wreg(0, 7, 8'h42);
        chk("R4 sync rewritten", cfg_a[7*8 +: 8], 8'h42);
        chk("R4 alternate held", alt7_a, 8'h3C);

        // R5: shared register 9
        wreg(1, 9, 8'hC5);
        chk("R5 shared seen on A", cfg_a[9*8 +: 8], 8'h05);
        wreg(0, 9, 8'h6A);
        chk("R5 shared seen on B", cfg_b[9*8 +: 8], 8'h2A);

        // R6: register 14 store mask and every command code
        for (int k = 0; k < 8; k++) wreg(0, 14, 8'((k << 5) | 5'h1B));
        wreg(1, 14, 8'hFF);
        chk("R6 kept bits B", cfg_b[14*8 +: 8], 8'h1F);

        // R7: interrupt pending only through channel A
        irq_pend = 6'h2D;
        rreg(0, 3);
        chk("R7 pending A", rd_data, 8'h2D);
        rreg(1, 3);
        chk("R7 pending B zero", rd_data, 8'h00);
        chk("R7 no error on B", acc_err, 1'b0);

        // R8: special-condition and clock-recovery status
        spc_a = 8'h9A; spc_b = 8'h61; dpll_st_a = 8'h12; dpll_st_b = 8'hC0;
        rreg(0, 1);
        chk("R8 spc A", rd_data, 8'h9A);
        rreg(1, 10);
        chk("R8 dpll status B", rd_data, 8'hC0);

        // R9: data register through both paths
        rxd_a = 8'h5E; rxd_b = 8'hB7;
        acc(0, 1, 1, 8'h55);
        chk("R9 data port tx A", txd_a, 8'h55);
        wreg(1, 8, 8'h99);
        chk("R9 pointer tx B", txd_b, 8'h99);
        acc(1, 1, 0, 8'h00);
        chk("R9 data port rx B", rd_data, 8'hB7);
        rreg(0, 8);
        chk("R9 pointer rx A", rd_data, 8'h5E);

        // R11: bad pointer value and undefined reads
        acc(0, 0, 1, 8'h20, 0);
        chk("R11 bad pointer error", acc_err, 1'b1);
        idle(5);
        acc(0, 0, 0, 8'h00);
        chk("R11 pointer stayed zero", rd_data, 8'hA5);
        rreg(1, 5);
        chk("R11 undefined read", rd_data, 8'h00);
        rreg(0, 13);
        acc(1, 0, 0, 8'h00);
        chk("R11 pointer cleared after error", rd_data, 8'h3C);

        // R10: back-to-back accesses and saturation
        acc(0, 1, 0, 8'h00, 0);
        acc(0, 1, 0, 8'h00, 0);
        acc(0, 1, 0, 8'h00, 6);
        chk("R10 two violations", viol_cnt, 8'd2);
        for (int i = 0; i < 300; i++) acc(1, 1, 0, 8'h00, 0);
        idle(6);
        chk("R10 saturated", viol_cnt, 8'hFF);

        // R1: reset clears again
        rst_n = 0;
        idle(2);
        chk("R1 cfg_b after reset", cfg_b, 128'h0);
        chk("R1 alt7 after reset", alt7_a, 8'h00);
        rst_n = 1;
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule